// File: doc/BRIEF.md
# Sixteen-Source Interrupt Controller with Diagnostic Injection

This block gathers up to sixteen interrupt request lines into one CPU interrupt. A rising edge on any source line latches a pending bit in a status register. That bit stays set until software writes a one to it. A mask register selects which pending bits may raise the CPU line. The CPU interrupt is the OR of every pending bit that the mask enables. It is driven combinationally from the registered state, so it follows a status or mask change with no extra cycle.

A diagnostic injection input forces chosen pending bits on for as long as it is held, and software writes cannot clear them during that time. This lets a test environment present a stuck or recurring interrupt to firmware without real hardware activity. A build parameter picks how mask writes behave. In the default mode a write loads the mask. In the other mode each written one flips the matching mask bit, so firmware can change one bit without a read-modify-write.

Register access is a plain single-cycle port. There is one write strobe with an address and data, and a combinational read of whatever register the address selects. There is no handshake or back-pressure: a write always lands on the clock edge where the strobe is high.

Top module: `irq_ctl16`

## Requirements
- R1: While `rst` is high at a clock edge, status and mask are cleared, so after reset reads of 0x0 and 0x4 return 0 and `irq_o` is low.
- R2: A 0-to-1 change of `src_i[i]` between two clock edges sets pending bit i at the second edge. The bit stays set after the source falls. A source held high sets its bit only once.
- R3: A write to byte offset 0x0 clears each pending bit whose data bit is 1. Bits whose data bit is 0 are left unchanged.
- R4: With `MASK_XOR`=0, a write to byte offset 0x4 loads `wdata[15:0]` into the mask.
- R5: With `MASK_XOR`=1, a write to byte offset 0x4 makes the new mask equal to the old mask XOR `wdata[15:0]`.
- R6: `irq_o` is high exactly when some bit is both pending and enabled in the mask. It changes in the same cycle as the status or mask state it depends on.
- R7: While `inj_i[i]` is 1, pending bit i reads as 1 and cannot be cleared by a write to 0x0. Once `inj_i[i]` drops, the bit stays set until a later write to 0x0 clears it.
- R8: When a source rising edge and a clearing write to the same bit fall in the same cycle, the bit ends up set.
- R9: Reading offset 0x0 returns the pending bits in `rdata[15:0]`, and reading 0x4 returns the mask there. The upper bits of `rdata` are 0, and any other offset reads as 0. `wdata[31:16]` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| src_i | input | 16 | Interrupt source lines, edge sensitive |
| inj_i | input | 16 | Diagnostic injection, one bit per source |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset for both read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the register at `addr` |
| irq_o | output | 1 | CPU interrupt request |

## Verification
A corrupted pending bit shows up in the same cycle, on `rdata` at offset 0x0 and on `irq_o` whenever that bit is enabled. A corrupted mask shows on `rdata` at offset 0x4 and as a missing or extra `irq_o`. A broken edge detector is exposed by a source held high across a clear: the bit comes back one edge after the clearing write, when it should have stayed clear. The injection path is exposed by reading a bit after clearing it while injection is held, and again after injection drops.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned OFF_STAT = 0;
  localparam int unsigned OFF_MASK = 4;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= lvl_i;
  end

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_bit
      assign rise_o[g] = lvl_i[g] & ~lvl_q[g];
    end
  endgenerate
endmodule

// File: rtl/irq_stat_reg.sv
module irq_stat_reg #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] hold_i,
  output logic [N-1:0] stat_o
);
  logic [N-1:0] stat_q;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst)
          stat_q[g] <= 1'b0;
        else if (set_i[g] || hold_i[g])
          stat_q[g] <= 1'b1;
        else if (clr_i[g])
          stat_q[g] <= 1'b0;
      end
    end
  endgenerate

  // injected bits are visible at once, not one edge later
  assign stat_o = stat_q | hold_i;
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned N        = 16,
  parameter bit          MASK_XOR = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] nxt;

  generate
    if (MASK_XOR) begin : g_flip
      assign nxt = mask_o ^ d_i;
    end else begin : g_load
      assign nxt = d_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       mask_o <= '0;
    else if (we_i) mask_o <= nxt;
  end
endmodule

// File: rtl/irq_ctl16.sv
module irq_ctl16
  import irq_ctl_pkg::*;
#(
  parameter int unsigned N        = 16,
  parameter int unsigned ADDR_W   = 8,
  parameter bit          MASK_XOR = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      src_i,
  input  logic [N-1:0]      inj_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFF_MASK);

  logic [N-1:0] rise;
  logic [N-1:0] stat_q;
  logic [N-1:0] mask_q;
  logic         hit_stat;
  logic         hit_mask;

  assign hit_stat = (addr == A_STAT);
  assign hit_mask = (addr == A_MASK);

  irq_edge_det #(.N(N)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (src_i),
    .rise_o (rise)
  );

  irq_stat_reg #(.N(N)) u_stat (
    .clk    (clk),
    .rst    (rst),
    .set_i  (rise),
    .clr_i  ((wr_en && hit_stat) ? wdata[N-1:0] : {N{1'b0}}),
    .hold_i (inj_i),
    .stat_o (stat_q)
  );

  irq_mask_reg #(.N(N), .MASK_XOR(MASK_XOR)) u_mask (
    .clk    (clk),
    .rst    (rst),
    .we_i   (wr_en && hit_mask),
    .d_i    (wdata[N-1:0]),
    .mask_o (mask_q)
  );

  always_comb begin
    rdata = '0;
    if (hit_stat)      rdata[N-1:0] = stat_q;
    else if (hit_mask) rdata[N-1:0] = mask_q;
  end

  assign irq_o = |(stat_q & mask_q);
endmodule

// File: rtl/irq_ctl16_chk.sv
module irq_ctl16_chk #(
  parameter int unsigned N        = 16,
  parameter int unsigned ADDR_W   = 8,
  parameter bit          MASK_XOR = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic [N-1:0]      src_i,
  input logic [N-1:0]      inj_i,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              irq_o,
  input logic [N-1:0]      stat_q,
  input logic [N-1:0]      mask_q
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (mask_q == '0) && ((stat_q & ~inj_i) == '0));

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == 0) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 0) |=> ((stat_q & $past(wdata[N-1:0] & ~src_i & ~inj_i)) == '0));

  // R4
  mask_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!MASK_XOR && wr_en && addr == 4) |=> (mask_q == $past(wdata[N-1:0])));

  // R5
  mask_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (MASK_XOR && wr_en && addr == 4) |=> (mask_q == $past(mask_q ^ wdata[N-1:0])));

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |-> !irq_o);

  // R7
  inj_visible_chk: assert property (@(posedge clk) disable iff (rst)
    (addr == 0) |-> ((rdata[N-1:0] & inj_i) == inj_i));

  // R9
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rdata[31:N] == '0);
endmodule

bind irq_ctl16 irq_ctl16_chk #(.N(N), .ADDR_W(ADDR_W), .MASK_XOR(MASK_XOR)) u_chk (
  .clk(clk), .rst(rst), .src_i(src_i), .inj_i(inj_i), .wr_en(wr_en),
  .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o),
  .stat_q(stat_q), .mask_q(mask_q)
);

// File: tb/irq_ctl16_test.sv
module irq_ctl16_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] src_i = '0;
  logic [15:0] inj_i = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_x;
  logic        irq_o, irq_x;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctl16 #(.MASK_XOR(1'b0)) uut (
    .clk(clk), .rst(rst), .src_i(src_i), .inj_i(inj_i), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o));

  irq_ctl16 #(.MASK_XOR(1'b1)) uut_x (
    .clk(clk), .rst(rst), .src_i(src_i), .inj_i(inj_i), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata_x), .irq_o(irq_x));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=%0d exp<%0d cycles", cyc, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v, output logic [31:0] vx);
    @(negedge clk);
    addr = a;
    #1;
    v = rdata; vx = rdata_x;
  endtask

  task automatic clear_all();
    inj_i = '0; src_i = '0;
    wr(8'h4, 32'h0);
    wr(8'h0, 32'hFFFF);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v, vx;
    rd(8'h0, v, vx); check("R1 stat", v, 0);
    rd(8'h4, v, vx); check("R1 mask", v, 0);
    check("R1 irq", {31'b0, irq_o}, 0);
  endtask

  task automatic t_edge();
    logic [31:0] v, vx;
    @(negedge clk); src_i[3] = 1'b1;
    @(negedge clk); src_i[3] = 1'b0;
    rd(8'h0, v, vx); check("R2 sticky after fall", v, 32'h8);
    // held-high source must not re-set its bit after a clear
    @(negedge clk); src_i[7] = 1'b1;
    @(negedge clk);
    wr(8'h0, 32'h80);
    @(negedge clk);
    rd(8'h0, v, vx); check("R2 held high once", v, 32'h8);
    src_i[7] = 1'b0;
  endtask

  task automatic t_w1c();
    logic [31:0] v, vx;
    @(negedge clk); src_i[0] = 1'b1; src_i[9] = 1'b1;
    @(negedge clk); src_i = '0;
    rd(8'h0, v, vx); check("R3 pre", v, 32'h209);
    wr(8'h0, 32'h0000_0201);
    rd(8'h0, v, vx); check("R3 partial clear", v, 32'h8);
    wr(8'h0, 32'h0);
    rd(8'h0, v, vx); check("R3 zero write", v, 32'h8);
  endtask

  task automatic t_mask();
    logic [31:0] v, vx;
    wr(8'h4, 32'hABCD_00F0);
    rd(8'h4, v, vx);
    check("R4 load", v, 32'h00F0);
    check("R9 upper wdata ignored", v[31:16], 0);
    check("R5 xor first", vx, 32'h00F0);
    wr(8'h4, 32'h0000_0030);
    rd(8'h4, v, vx);
    check("R4 load again", v, 32'h0030);
    check("R5 xor flip", vx, 32'h00C0);
  endtask

  task automatic t_irq();
    logic [31:0] v, vx;
    clear_all();
    wr(8'h4, 32'h0010);
    @(negedge clk); src_i[2] = 1'b1;
    @(negedge clk); src_i[2] = 1'b0;
    check("R6 masked off", {31'b0, irq_o}, 0);
    @(negedge clk); src_i[4] = 1'b1;
    @(negedge clk); src_i[4] = 1'b0;
    check("R6 enabled pending", {31'b0, irq_o}, 1);
    wr(8'h0, 32'h0010);
    check("R6 cleared", {31'b0, irq_o}, 0);
    rd(8'h0, v, vx); check("R6 other pending kept", v, 32'h4);
  endtask

  task automatic t_inject();
    logic [31:0] v, vx;
    clear_all();
    wr(8'h4, 32'h1000);
    @(negedge clk); inj_i[12] = 1'b1;
    #1;
    check("R7 irq on inject", {31'b0, irq_o}, 1);
    rd(8'h0, v, vx); check("R7 visible", v, 32'h1000);
    wr(8'h0, 32'h1000);
    rd(8'h0, v, vx); check("R7 not clearable", v, 32'h1000);
    @(negedge clk); inj_i[12] = 1'b0;
    rd(8'h0, v, vx); check("R7 sticky after drop", v, 32'h1000);
    wr(8'h0, 32'h1000);
    rd(8'h0, v, vx); check("R7 clearable after drop", v, 0);
  endtask

  task automatic t_race();
    logic [31:0] v, vx;
    clear_all();
    @(negedge clk); src_i[5] = 1'b1;
    @(negedge clk); src_i[5] = 1'b0;
    // rising edge and W1C in the same cycle
    @(negedge clk);
    src_i[5] = 1'b1; wr_en = 1'b1; addr = 8'h0; wdata = 32'h20;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0; src_i[5] = 1'b0;
    rd(8'h0, v, vx); check("R8 edge wins", v, 32'h20);
  endtask

  task automatic t_read();
    logic [31:0] v, vx;
    wr(8'h4, 32'h5555);
    rd(8'h8, v, vx); check("R9 other offset", v, 0);
    rd(8'h1, v, vx); check("R9 unaligned offset", v, 0);
    rd(8'h4, v, vx); check("R9 mask read", v, 32'h5555);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_edge();
    t_w1c();
    t_mask();
    t_irq();
    t_inject();
    t_race();
    t_read();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule